// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models a small synchronous burst SRAM: 64 words of 32 bits behind a clocked command interface. On every rising clock edge it reads two address strobes, an advance input and three chip enables, and classifies the cycle. A cycle is idle, a deselect, or a read or write that starts a four-beat burst, steps to the next beat, or holds the current beat. Burst beats follow either a linear or an interleaved order, selected by a mode input. The write inputs are decoded into per-byte-lane enables. Write data is captured on the same edge that presents the address.

Read data leaves through an output register. The register works in one of two modes: flow-through, where data is presented after the accepting edge, or pipelined, which adds one more edge of latency. The shared bidirectional bus is represented by separate data-in, data-out and output-enable signals. The output enable is gated asynchronously by the output-enable pin and by the power-down input. While powered down, the array and the burst position are retained and every synchronous input is ignored.

Top module: `burst_sram_ctl`

## Requirements
- R1: With `ce1_n` high, a low `cpu_strb_n` is ignored. The cycle is decoded as though that strobe were high, so an active burst continues or holds according to `adv_n`.
- R2: `ce2` (active high) and `ce3_n` (active low) matter only in a cycle where an address strobe is accepted. If either is inactive then, the cycle is a deselect and the bus is released. Changing them in other cycles has no effect.
- R3: An accepted `cpu_strb_n` (low with `ce1_n` low and both other enables active) starts a read burst at `addr`, whatever the write inputs are.
- R4: A low `ctl_strb_n` without an accepted `cpu_strb_n` starts a burst at `addr` when `ce1_n`, `ce2` and `ce3_n` are all active. The burst is a write if any lane is enabled and a read otherwise. If any enable is inactive, the cycle is a deselect.
- R5: With no strobe accepted and a burst active, `adv_n` low moves to the next beat and `adv_n` high stays on the current beat. The cycle is a write if any lane is enabled, otherwise a read. With no burst active, nothing happens.
- R6: `wr_all_n` low writes all four lanes. Otherwise `wr_byte_n` low writes lane n when `lane_wr_n[n]` is low, where lane n is bits 8n+7:8n. With both high, no lane is written.
- R7: Beats are numbered 0 to 3. For a start offset s = `addr[1:0]`, beat k uses low address bits (s+k) mod 4 when `lin_order` is 1 and s XOR k when it is 0. The upper bits stay fixed, and the sequence wraps after beat 3.
- R8: With `pipe_en` 0, read data for a cycle is valid from the edge that accepts the read. With `pipe_en` 1, it is valid from the following edge.
- R9: `data_oe` is high only while valid read data is present, `oe_n` is low and `pwrdn` is low. It follows `oe_n` without waiting for a clock, and it is low after writes and deselects.
- R10: While `pwrdn` is high, strobes and writes are ignored, `data_oe` is low, and the array contents and burst position are kept. Normal decoding resumes on the first edge after `pwrdn` falls.
- R11: A write stores `data_in` into the addressed word on the edge that presents the write cycle, in both output modes.
- R12: After reset, no burst is active and `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | External word address |
| cpu_strb_n | input | 1 | Processor-side address strobe, masked by `ce1_n` |
| ctl_strb_n | input | 1 | Controller-side address strobe |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high, sampled with a strobe |
| ce3_n | input | 1 | Chip enable 3, active low, sampled with a strobe |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pwrdn | input | 1 | Power-down, active high |
| pipe_en | input | 1 | 1 selects pipelined output, 0 flow-through |
| lin_order | input | 1 | 1 selects linear burst order, 0 interleaved |
| data_in | input | 32 | Write data from the bus |
| data_out | output | 32 | Read data toward the bus |
| data_oe | output | 1 | Bus drive enable |

## Verification
The assertions check on every cycle the properties that follow from one or two edges of input history:
- a deselect after a strobe with a disabled enable;
- an accepted processor strobe yielding read data;
- the bus staying quiet after power-down;
- burst restart and hold;
- the one-edge or two-edge read latency.

Only the bench scenarios can show the end-to-end facts:
- stored data surviving power-down;
- correct per-lane merging of byte writes;
- the full linear and interleaved wrap sequences;
- chip enables 2 and 3 being ignored in the middle of a burst.

For these, the bench compares every cycle's bus against a behavioural model of the array.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_DESEL = 3'd1,
    OP_BEGIN = 3'd2,
    OP_CONT  = 3'd3,
    OP_SUSP  = 3'd4
  } op_e;
endpackage

// File: rtl/lane_decode.sv
module lane_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_we,
  output logic             any_we
);
  always_comb begin
    if (!wr_all_n)       lane_we = '1;
    else if (!wr_byte_n) lane_we = ~lane_wr_n;
    else                 lane_we = '0;
    any_we = |lane_we;
  end
endmodule

// File: rtl/cyc_decode.sv
module cyc_decode
  import sram_burst_pkg::*;
(
  input  logic cpu_strb_n,
  input  logic ctl_strb_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic pwrdn,
  input  logic active,
  input  logic any_we,
  output op_e  op,
  output logic is_wr
);
  logic cpu_ok;
  logic sel_ok;

  always_comb begin
    cpu_ok = !cpu_strb_n && !ce1_n;
    sel_ok = ce2 && !ce3_n;
    op     = OP_NONE;
    is_wr  = 1'b0;
    if (pwrdn) begin
      op = OP_NONE;
    end else if (cpu_ok) begin
      op = sel_ok ? OP_BEGIN : OP_DESEL;
    end else if (!ctl_strb_n) begin
      op    = (!ce1_n && sel_ok) ? OP_BEGIN : OP_DESEL;
      is_wr = any_we;
    end else if (active) begin
      op    = adv_n ? OP_SUSP : OP_CONT;
      is_wr = any_we;
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              lin_order,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int OFS_W = 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFS_W-1:0]  cnt_q, cnt_d, step;
  logic              ld_en;

  function automatic logic [OFS_W-1:0] beat_ofs(input logic [OFS_W-1:0] s,
                                                input logic [OFS_W-1:0] k,
                                                input logic lin);
    return lin ? (s + k) : (s ^ k);
  endfunction

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    step     = cnt_q;
    ld_en    = 1'b0;
    eff_addr = {base_q[ADDR_W-1:OFS_W], beat_ofs(base_q[OFS_W-1:0], cnt_q, lin_order)};
    case (op)
      OP_BEGIN: begin
        base_d   = ext_addr;
        cnt_d    = '0;
        ld_en    = 1'b1;
        eff_addr = ext_addr;
      end
      OP_CONT: begin
        step     = cnt_q + 1'b1;
        cnt_d    = step;
        ld_en    = 1'b1;
        eff_addr = {base_q[ADDR_W-1:OFS_W], beat_ofs(base_q[OFS_W-1:0], step, lin_order)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (ld_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_BEGIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_BEGIN |=> (cnt_q == '0) && (base_q == $past(ext_addr))); // R7

  AST_HOLD_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUSP || op == OP_NONE || op == OP_DESEL) |=> $stable(base_q) && $stable(cnt_q)); // R5
endmodule

// File: rtl/rd_outreg.sv
module rd_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn,
  input  logic              capture,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              pipe_en,
  output logic [DATA_W-1:0] q,
  output logic              valid
);
  logic [DATA_W-1:0] d1_q, d2_q;
  logic              v1_q, v2_q, v1_d, v2_d;

  always_comb begin
    v1_d = capture && !pwrdn;
    v2_d = v1_q && !pwrdn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) d1_q <= rd_data;
    if (v1_q)    d2_q <= d1_q;
  end

  always_comb begin
    q     = pipe_en ? d2_q : d1_q;
    valid = pipe_en ? v2_q : v1_q;
  end

  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_en && valid) |-> $past(capture)); // R8

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && valid && $past(rst_n)) |-> $past(capture, 2)); // R8
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              oe_n,
  input  logic              pwrdn,
  input  logic              pipe_en,
  input  logic              lin_order,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [LANES-1:0]  lane_we;
  logic              any_we;
  op_e               op;
  logic              is_wr;
  logic              active_q, active_d;
  logic [ADDR_W-1:0] eff_addr;
  logic              xfer, capture;
  logic [LANES-1:0]  wr_en;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  lane_decode #(.LANES(LANES)) i_lane_decode (
    .wr_all_n (wr_all_n),
    .wr_byte_n(wr_byte_n),
    .lane_wr_n(lane_wr_n),
    .lane_we  (lane_we),
    .any_we   (any_we)
  );

  cyc_decode i_cyc_decode (
    .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n),
    .adv_n     (adv_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .pwrdn     (pwrdn),
    .active    (active_q),
    .any_we    (any_we),
    .op        (op),
    .is_wr     (is_wr)
  );

  burst_seq #(.ADDR_W(ADDR_W)) i_burst_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .ext_addr (addr),
    .lin_order(lin_order),
    .eff_addr (eff_addr)
  );

  always_comb begin
    xfer     = (op == OP_BEGIN) || (op == OP_CONT) || (op == OP_SUSP);
    capture  = xfer && !is_wr;
    wr_en    = (xfer && is_wr) ? lane_we : '0;
    active_d = active_q;
    if (op == OP_BEGIN)      active_d = 1'b1;
    else if (op == OP_DESEL) active_d = 1'b0;
    rd_data  = mem[eff_addr];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) active_q <= 1'b0;
    else             active_q <= active_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[eff_addr][g*LANE_W +: LANE_W] <= data_in[g*LANE_W +: LANE_W];
    end
  end

  rd_outreg #(.DATA_W(DATA_W)) i_rd_outreg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pwrdn  (pwrdn),
    .capture(capture),
    .rd_data(rd_data),
    .pipe_en(pipe_en),
    .q      (data_out),
    .valid  (rd_valid)
  );

  assign data_oe = rd_valid && !oe_n && !pwrdn;

  AST_CPU_STROBE_READS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pwrdn && !cpu_strb_n && !ce1_n && ce2 && !ce3_n && !pipe_en)
      |=> (data_oe || pwrdn || oe_n || pipe_en)); // R3

  AST_DESEL_RELEASES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pwrdn && !pipe_en && (!ctl_strb_n || (!cpu_strb_n && !ce1_n)) && (!ce2 || ce3_n))
      |=> !data_oe || pipe_en); // R2

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pwrdn && !pipe_en && ce1_n && !cpu_strb_n && ctl_strb_n && !active_q)
      |=> !data_oe || pipe_en); // R1

  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwrdn |=> !data_oe); // R10
endmodule

// File: tb/test_burst_sram_ctl.sv
`timescale 1ns/1ps
module test_burst_sram_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        cpu_strb_n, ctl_strb_n, adv_n, ce1_n, ce2, ce3_n;
  logic        wr_all_n, wr_byte_n, oe_n, pwrdn, pipe_en, lin_order;
  logic [3:0]  lane_wr_n;
  logic [31:0] data_in;
  logic [31:0] data_out;
  logic        data_oe;

  int checks = 0;
  int errors = 0;
  string cur_req = "R12";
  logic [31:0] seed_word = 32'h1234_5678;

  always #4 clk = ~clk;

  burst_sram_ctl i_burst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n), .pwrdn(pwrdn),
    .pipe_en(pipe_en), .lin_order(lin_order), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe)
  );

  // behavioural reference model
  logic [31:0] m_mem [64];
  bit          m_known [64];
  bit          m_active;
  int          m_base, m_cnt;
  bit          m_v1, m_v2, m_k1, m_k2;
  logic [31:0] m_d1, m_d2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active <= 0; m_v1 <= 0; m_v2 <= 0; m_base <= 0; m_cnt <= 0;
    end else if (pwrdn) begin
      m_v1 <= 0; m_v2 <= 0;
    end else begin
      int lanes, kind, k, a, start;
      bit wr;
      lanes = !wr_all_n ? 15 : (!wr_byte_n ? int'(~lane_wr_n) & 15 : 0);
      kind = 0; wr = 0; k = m_cnt; a = 0;
      if (!cpu_strb_n && !ce1_n) kind = (ce2 && !ce3_n) ? 2 : 1;
      else if (!ctl_strb_n) begin
        kind = (!ce1_n && ce2 && !ce3_n) ? 2 : 1;
        wr = (lanes != 0);
      end else if (m_active) begin
        kind = adv_n ? 4 : 3;
        wr = (lanes != 0);
      end
      if (kind == 2) begin
        a = int'(addr); m_base <= int'(addr); m_cnt <= 0; m_active <= 1;
      end else if (kind >= 3) begin
        if (kind == 3) begin k = (m_cnt + 1) % 4; m_cnt <= k; end
        start = m_base % 4;
        a = (m_base / 4) * 4 + (lin_order ? (start + k) % 4 : (start ^ k));
      end else if (kind == 1) m_active <= 0;
      m_v2 <= m_v1; m_d2 <= m_d1; m_k2 <= m_k1;
      if (kind >= 2 && wr) begin
        for (int b = 0; b < 4; b++)
          if (lanes[b]) m_mem[a][8*b +: 8] <= data_in[8*b +: 8];
        m_known[a] <= m_known[a] | (lanes == 15);
        m_v1 <= 0;
      end else if (kind >= 2) begin
        m_v1 <= 1; m_d1 <= m_mem[a]; m_k1 <= m_known[a];
      end else m_v1 <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_oe, kn;
    logic [31:0] exp_d;
    exp_oe = (pipe_en ? m_v2 : m_v1) && !oe_n && !pwrdn;
    exp_d  = pipe_en ? m_d2 : m_d1;
    kn     = pipe_en ? m_k2 : m_k1;
    chk(data_oe === exp_oe, {cur_req, " data_oe"}, {31'd0, data_oe}, {31'd0, exp_oe});
    if (exp_oe && kn) chk(data_out === exp_d, {cur_req, " data_out"}, data_out, exp_d);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cpu_strb_n = 1; ctl_strb_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF;
  endtask

  function automatic logic [31:0] next_word();
    seed_word = seed_word * 32'h0019_660D + 32'h3C6E_F35F;
    return seed_word;
  endfunction

  task automatic wr_burst(input logic [5:0] a);
    ctl_strb_n = 0; addr = a; wr_all_n = 0; data_in = next_word();
    step();
    ctl_strb_n = 1;
    for (int k = 1; k < 4; k++) begin
      adv_n = 0; data_in = next_word();
      step();
    end
    idle();
  endtask

  task automatic rd_burst(input logic [5:0] a, input int beats);
    cpu_strb_n = 0; addr = a; wr_all_n = 0;   // R3: write input ignored
    step();
    idle();
    for (int k = 1; k < beats; k++) begin
      adv_n = 0;
      step();
    end
    idle();
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0; addr = 0; oe_n = 0; pwrdn = 0; pipe_en = 0; lin_order = 1; data_in = 0;
    for (int i = 0; i < 64; i++) m_known[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    cur_req = "R12";
    chk(data_oe === 1'b0, "R12 reset oe", {31'd0, data_oe}, 32'd0);

    // R4 R11 R7: fill the array with write bursts, flow-through
    cur_req = "R11";
    for (int i = 0; i < 16; i++) wr_burst(6'(i * 4 + (i % 4)));
    idle(); ctl_strb_n = 0; ce2 = 0; step(); idle();   // deselect
    step();

    cur_req = "R7";
    rd_burst(6'd6, 6);       // linear wrap
    lin_order = 0;
    rd_burst(6'd45, 4);      // interleaved
    lin_order = 1;

    cur_req = "R5";
    rd_burst(6'd17, 2);
    repeat (3) step();       // hold at current beat

    cur_req = "R1";
    rd_burst(6'd32, 1);
    cpu_strb_n = 0; ce1_n = 1; adv_n = 0; addr = 6'd0;
    step(); step();
    idle();

    cur_req = "R2";
    rd_burst(6'd20, 1);
    ce2 = 0; ce3_n = 1; adv_n = 0; step(); step();   // ignored mid-burst
    idle(); cpu_strb_n = 0; ce3_n = 1; addr = 6'd8; step();  // deselect
    idle(); step(); step();
    chk(data_oe === 1'b0, "R2 deselect released bus", {31'd0, data_oe}, 32'd0);

    cur_req = "R4";
    ctl_strb_n = 0; addr = 6'd12; step(); idle(); step();    // read via ctl strobe

    cur_req = "R6";
    ctl_strb_n = 0; addr = 6'd40; wr_byte_n = 0; lane_wr_n = 4'b1010; data_in = 32'hDEAD_BEEF;
    step();
    idle(); wr_byte_n = 0; lane_wr_n = 4'b0111; data_in = 32'h5A5A_5A5A; step();  // suspend write lane 3
    idle(); wr_byte_n = 1; wr_all_n = 1; lane_wr_n = 4'h0; data_in = 32'hFFFF_FFFF; step(); // no write
    idle(); rd_burst(6'd40, 1); step();
    chk(data_out[7:0] === 8'hEF && data_out[23:16] === 8'hAD, "R6 lanes merged",
        data_out, 32'h00AD_00EF | (data_out & 32'hFF00_FF00));

    cur_req = "R9";
    rd_burst(6'd3, 1);
    oe_n = 1; #1;
    chk(data_oe === 1'b0, "R9 async oe off", {31'd0, data_oe}, 32'd0);
    oe_n = 0; #1;
    chk(data_oe === 1'b1, "R9 async oe on", {31'd0, data_oe}, 32'd1);
    ctl_strb_n = 0; addr = 6'd3; wr_all_n = 0; data_in = 32'h0BAD_F00D; step();
    idle(); step();

    cur_req = "R10";
    pwrdn = 1; ctl_strb_n = 0; addr = 6'd3; wr_all_n = 0; data_in = 32'h1111_2222;
    step();
    chk(data_oe === 1'b0, "R10 standby quiet", {31'd0, data_oe}, 32'd0);
    cpu_strb_n = 0; step(); step();
    idle(); pwrdn = 0; step();
    rd_burst(6'd3, 1); step();
    chk(data_out === 32'h0BAD_F00D, "R10 contents kept", data_out, 32'h0BAD_F00D);

    cur_req = "R8";
    idle(); ctl_strb_n = 0; ce2 = 0; step(); idle(); step();
    pipe_en = 1; step(); step();
    rd_burst(6'd9, 4); step(); step();
    cur_req = "R11";
    wr_burst(6'd28);
    rd_burst(6'd28, 4); step(); step();
    cur_req = "R2";
    idle(); ctl_strb_n = 0; ce2 = 0; step(); idle(); step(); step();
    chk(data_oe === 1'b0, "R8 pipe bus off", {31'd0, data_oe}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule